// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on one output line. The host writes through a small register port: one address holds the next byte to send, another holds the frame format. The format covers word length (5 to 8 bits), an optional parity bit that can be even, odd or fixed at a constant level, a stop period of 1, 1.5 or 2 bit times, and a break control that pulls the line low.

Bit timing comes from an external oversampling enable, `tick_en`, that pulses once per sixteenth of a bit. The serializer takes a waiting byte as soon as the previous frame's stop period ends, so a host that refills the holding register while `ready_n` is low gets frames with no idle time between them. The frame format is captured when a byte is taken, so a format write during a frame affects only later frames.

The control is one state machine with states IDLE, START, DATA, PARITY and STOP. The transitions are: IDLE to START when the holding register is full (load); START to DATA after one bit time; DATA to DATA after each bit time while data bits remain; DATA to PARITY after the last data bit when parity is enabled, otherwise DATA to STOP; PARITY to STOP after one bit time; STOP to START when the stop period ends and a byte is waiting (back-to-back load); STOP to IDLE when the stop period ends and the holding register is empty. Reset from any state goes to IDLE.

Top module: `async_frame_tx`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the holding register, abandons any frame in progress and clears the format register to zero. After reset `ser_out` is 1, `ready_n` is 0 and `tx_empty` is 1, and a byte written next is sent as 5 data bits with no parity and 1 stop bit.
- R2: A write occurs only on a clock edge with `sel` and `wr_en` both high. Address 0 writes the holding register and address 3 writes the format register. Writes at any other address, or with `sel` or `wr_en` low, change nothing.
- R3: A frame is a start bit (0), then the data bits least significant first, then the parity bit if enabled, then the stop period (1). The line rests at 1 when no frame is being sent.
- R4: Format bits [1:0] set the word length: 00, 01, 10 and 11 give 5, 6, 7 and 8 bits. Data bits above the word length are not sent.
- R5: Format bit 3 enables parity. Format bit 4 set means even parity and clear means odd parity. Normal parity covers only the bits actually sent, so 0x55 with 5-bit words and even parity gives a parity bit of 1.
- R6: When format bit 5 (stick) is set along with parity, the parity bit ignores the data: it is 0 when bit 4 is set and 1 when bit 4 is clear.
- R7: Format bit 2 clear gives a stop period of 16 ticks. Bit 2 set gives 24 ticks for 5-bit words and 32 ticks for longer words.
- R8: Every start, data and parity bit lasts exactly 16 `tick_en` pulses. The line changes only on an edge where `tick_en` is high, on a load, or on a format write.
- R9: `ready_n` goes to 1 on the edge that writes the holding register and returns to 0 on the edge where the serializer takes the byte.
- R10: `tx_empty` is 1 only while the holding register is empty and no frame is in progress. It rises on the edge where the last stop period ends.
- R11: A byte waiting when a stop period ends starts its start bit on that same edge, with no idle time in between.
- R12: While format bit 6 (break) is set, `ser_out` is 0. Frame timing keeps running underneath, so the frame continues on schedule once break clears.
- R13: The word length, parity and stop settings are captured when a byte is taken. A format write during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| tick_en | input | 1 | Oversampling enable, 16 pulses per bit |
| sel | input | 1 | Register port select |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address (0 holding, 3 format) |
| wdata | input | 8 | Write data |
| ser_out | output | 1 | Serial line, idles high |
| ready_n | output | 1 | Low when the holding register can take a byte |
| tx_empty | output | 1 | High when holding register and shifter are both empty |

## Verification
The hardest case to reach from the ports is the edge where a stop period ends while a byte is already waiting. At that edge the stop count, the back-to-back load and the captured format for the next frame all meet. The bench reaches it by writing bursts of two or three bytes, each written as soon as `ready_n` drops, under random formats. A tick-accurate line model then checks every cycle of each frame and requires the next start bit on the exact tick that ends the stop period. Directed cases cover a break raised mid-frame, a format write mid-frame, and a reset mid-frame.

// File: rtl/aftx_pkg.sv
package aftx_pkg;

    localparam int          DATA_W        = 8;
    localparam logic [2:0]  DEF_HOLD_ADDR = 3'd0;
    localparam logic [2:0]  DEF_CTRL_ADDR = 3'd3;

    // Field positions follow the bit numbering of the format register.
    typedef struct packed {
        logic       brk;        // [6] force line low
        logic       stick;      // [5] constant parity
        logic       even;       // [4] even / odd select
        logic       par_en;     // [3] parity present
        logic       long_stop;  // [2] 1.5 or 2 stop bits
        logic [1:0] wlen;       // [1:0] word length minus 5
    } line_ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // Mask keeping only the bits that are sent.
    function automatic logic [DATA_W-1:0] word_mask(input logic [1:0] wlen);
        return {DATA_W{1'b1}} >> (2'd3 - wlen);
    endfunction

    function automatic logic frame_parity(input logic [DATA_W-1:0] data,
                                          input line_ctrl_t        c);
        logic [DATA_W-1:0] kept;
        kept = data & word_mask(c.wlen);
        if (c.stick)
            return ~c.even;
        return c.even ? ^kept : ~^kept;
    endfunction

endpackage

// File: rtl/aftx_host_regs.sv
module aftx_host_regs
    import aftx_pkg::*;
#(
    parameter int          ADDR_W    = 3,
    parameter logic [2:0]  HOLD_ADDR = DEF_HOLD_ADDR,
    parameter logic [2:0]  CTRL_ADDR = DEF_CTRL_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output line_ctrl_t        ctrl,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data
);

    logic hold_wr;
    logic ctrl_wr;

    assign hold_wr = sel && wr_en && (addr == ADDR_W'(HOLD_ADDR));
    assign ctrl_wr = sel && wr_en && (addr == ADDR_W'(CTRL_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= line_ctrl_t'(wdata[6:0]);
        end
    end

    // A write in the same cycle as a take keeps the register full.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (hold_wr) begin
            hold_full <= 1'b1;
            hold_data <= wdata;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

endmodule

// File: rtl/aftx_bit_timer.sv
module aftx_bit_timer #(
    parameter  int OSR = 16,
    localparam int TW  = $clog2(2 * OSR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          done
);

    logic [TW-1:0] cnt;

    assign done = run && tick_en && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick_en) begin
            cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/aftx_fsm.sv
module aftx_fsm
    import aftx_pkg::*;
#(
    parameter  int OSR = 16,
    localparam int TW  = $clog2(2 * OSR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  line_ctrl_t        ctrl,
    input  logic              bit_done,
    output logic              take,
    output logic              run,
    output logic [TW-1:0]     limit,
    output logic              line_bit,
    output logic              idle
);

    localparam logic [TW-1:0] LIM_BIT  = TW'(OSR - 1);
    localparam logic [TW-1:0] LIM_HALF = TW'(OSR + OSR / 2 - 1);
    localparam logic [TW-1:0] LIM_TWO  = TW'(2 * OSR - 1);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [2:0]        left_q;
    logic              par_en_q;
    logic              par_q;
    logic [TW-1:0]     stop_lim_q;
    logic [TW-1:0]     stop_lim_new;

    assign take = hold_full &&
                  ((state_q == ST_IDLE) || ((state_q == ST_STOP) && bit_done));

    always_comb begin
        if (!ctrl.long_stop)
            stop_lim_new = LIM_BIT;
        else if (ctrl.wlen == 2'b00)
            stop_lim_new = LIM_HALF;
        else
            stop_lim_new = LIM_TWO;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (hold_full) state_d = ST_START;
            ST_START:  if (bit_done)  state_d = ST_DATA;
            ST_DATA:
                if (bit_done && (left_q == 3'd0))
                    state_d = par_en_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_done)  state_d = ST_STOP;
            ST_STOP:
                if (bit_done)
                    state_d = hold_full ? ST_START : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Frame datapath: captured format and shifter
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q    <= '0;
            left_q     <= '0;
            par_en_q   <= 1'b0;
            par_q      <= 1'b0;
            stop_lim_q <= LIM_BIT;
        end else if (take) begin
            shreg_q    <= hold_data;
            left_q     <= 3'(ctrl.wlen) + 3'd4;
            par_en_q   <= ctrl.par_en;
            par_q      <= frame_parity(hold_data, ctrl);
            stop_lim_q <= stop_lim_new;
        end else if ((state_q == ST_DATA) && bit_done) begin
            shreg_q <= shreg_q >> 1;
            if (left_q != 3'd0)
                left_q <= left_q - 3'd1;
        end
    end

    // Outputs
    always_comb begin
        line_bit = 1'b1;
        run      = 1'b1;
        idle     = 1'b0;
        limit    = LIM_BIT;
        unique case (state_q)
            ST_IDLE: begin
                run  = 1'b0;
                idle = 1'b1;
            end
            ST_START:  line_bit = 1'b0;
            ST_DATA:   line_bit = shreg_q[0];
            ST_PARITY: line_bit = par_q;
            ST_STOP:   limit    = stop_lim_q;
            default: begin
                run  = 1'b0;
                idle = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
    import aftx_pkg::*;
#(
    parameter int          OSR       = 16,
    parameter int          ADDR_W    = 3,
    parameter logic [2:0]  HOLD_ADDR = DEF_HOLD_ADDR,
    parameter logic [2:0]  CTRL_ADDR = DEF_CTRL_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              ser_out,
    output logic              ready_n,
    output logic              tx_empty
);

    localparam int TW = $clog2(2 * OSR);

    line_ctrl_t        ctrl;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              run;
    logic [TW-1:0]     limit;
    logic              bit_done;
    logic              line_bit;
    logic              idle;
    logic              brk_on;

    aftx_host_regs #(
        .ADDR_W    (ADDR_W),
        .HOLD_ADDR (HOLD_ADDR),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .take      (take),
        .ctrl      (ctrl),
        .hold_full (hold_full),
        .hold_data (hold_data)
    );

    aftx_bit_timer #(.OSR(OSR)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .run     (run),
        .limit   (limit),
        .done    (bit_done)
    );

    aftx_fsm #(.OSR(OSR)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .ctrl      (ctrl),
        .bit_done  (bit_done),
        .take      (take),
        .run       (run),
        .limit     (limit),
        .line_bit  (line_bit),
        .idle      (idle)
    );

    assign brk_on   = ctrl.brk;
    assign ser_out  = brk_on ? 1'b0 : line_bit;
    assign ready_n  = hold_full;
    assign tx_empty = idle && !hold_full;

endmodule

// File: rtl/aftx_checker.sv
module aftx_checker
    import aftx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_en,
    input logic       sel,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic       ser_out,
    input logic       ready_n,
    input logic       tx_empty,
    input logic       brk,
    input logic       take
);

    logic data_wr;
    logic ctrl_wr;

    assign data_wr = sel && wr_en && (addr == DEF_HOLD_ADDR);
    assign ctrl_wr = sel && wr_en && (addr == DEF_CTRL_ADDR);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !brk) |-> ser_out); // R3

    AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !take && !ctrl_wr) |=> $stable(ser_out)); // R8

    AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> ready_n); // R9

    AST_TAKE_FREES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (take && !data_wr) |=> !ready_n); // R9

    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !data_wr) |=> tx_empty); // R10

endmodule

bind async_frame_tx aftx_checker u_aftx_checker (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .sel      (sel),
    .wr_en    (wr_en),
    .addr     (addr),
    .ser_out  (ser_out),
    .ready_n  (ready_n),
    .tx_empty (tx_empty),
    .brk      (brk_on),
    .take     (take)
);

// File: tb/test_async_frame_tx.sv
module test_async_frame_tx;

    localparam int TICK_DIV = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic       ser_out, ready_n, tx_empty;

    always #5 clk = ~clk;

    async_frame_tx i_async_frame_tx (
        .clk(clk), .rst(rst), .tick_en(tick_en), .sel(sel), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .ser_out(ser_out), .ready_n(ready_n),
        .tx_empty(tx_empty)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- expected-value functions ----------------
    function automatic int nbits(input logic [6:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic logic par_of(input logic [7:0] d, input logic [6:0] c);
        int ones = 0;
        for (int i = 0; i < nbits(c); i++) ones += int'(d[i]);
        if (c[5]) return ~c[4];
        return c[4] ? logic'(ones % 2) : ~logic'(ones % 2);
    endfunction

    function automatic int stop_ticks(input logic [6:0] c);
        if (!c[2]) return 16;
        return (c[1:0] == 2'b00) ? 24 : 32;
    endfunction

    function automatic int frame_ticks(input logic [6:0] c);
        return 16 * (1 + nbits(c) + int'(c[3])) + stop_ticks(c);
    endfunction

    function automatic logic exp_level(input logic [7:0] d, input logic [6:0] c,
                                       input int tc);
        int b = tc / 16;
        if (b == 0) return 1'b0;
        if (b <= nbits(c)) return d[b-1];
        if (c[3] && b == nbits(c) + 1) return par_of(d, c);
        return 1'b1;
    endfunction

    // ---------------- write model (R2) ----------------
    logic [7:0] fq_d [256];
    logic [6:0] fq_c [256];
    int         wp = 0;
    logic [6:0] cfg_m = 7'd0;
    bit         brk_now = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            cfg_m   <= 7'd0;
            brk_now <= 1'b0;
        end else if (sel && wr_en) begin
            if (addr == 3'd0) begin
                fq_d[wp % 256] <= wdata;
                fq_c[wp % 256] <= cfg_m;
                wp <= wp + 1;
            end else if (addr == 3'd3) begin
                cfg_m   <= wdata[6:0];
                brk_now <= wdata[6];
            end
        end
    end

    // ---------------- tick generator and line monitor ----------------
    int         rp = 0;
    bit         rx_active = 1'b0;
    int         tc = 0;
    int         tick_cnt = 0;
    logic [7:0] cur_d;
    logic [6:0] cur_c;
    bit         frame_ok;
    int         bad_tc, bad_got, bad_exp;
    logic       last_par = 1'b0;

    always @(negedge clk) begin
        bit t;
        t = tick_en;
        tick_cnt = (tick_cnt + 1) % TICK_DIV;
        tick_en  = (tick_cnt == 0);
        if (rst) begin
            rx_active = 1'b0;
            rp = wp;
        end else begin
            if (rx_active) begin
                if (t) tc++;
                if (tc == frame_ticks(cur_c)) begin
                    check(frame_ok, "R3/R4/R5/R6/R7/R8",
                          $sformatf("frame d=%0h cfg=%0h at tick %0d", cur_d, cur_c, bad_tc),
                          bad_got, bad_exp);
                    rx_active = 1'b0;
                    if (rp != wp)
                        check(ser_out === 1'b0, "R11", "next start on stop end",
                              int'(ser_out), 0);
                    else
                        check(ser_out === 1'b1 && tx_empty === 1'b1, "R10",
                              "empty at stop end", int'({ser_out, tx_empty}), 3);
                end else begin
                    logic e;
                    e = brk_now ? 1'b0 : exp_level(cur_d, cur_c, tc);
                    if (cur_c[3] && tc == 16 * (nbits(cur_c) + 1) + 8) last_par = ser_out;
                    if (frame_ok && (ser_out !== e || tx_empty !== 1'b0)) begin
                        frame_ok = 1'b0;
                        bad_tc = tc; bad_got = int'({tx_empty, ser_out}); bad_exp = int'(e);
                    end
                end
            end
            if (!rx_active) begin
                if (rp != wp && !brk_now && ser_out === 1'b0) begin
                    cur_d = fq_d[rp % 256];
                    cur_c = fq_c[rp % 256];
                    rp++;
                    tc = 0;
                    rx_active = 1'b1;
                    frame_ok = 1'b1;
                    bad_tc = 0; bad_got = 0; bad_exp = 0;
                end else if (!brk_now && ser_out !== 1'b1) begin
                    check(1'b0, "R3", "idle line level", int'(ser_out), 1);
                end
            end
        end
    end

    // ---------------- host tasks ----------------
    task automatic host_wr(input logic s, input logic w, input logic [2:0] a,
                           input logic [7:0] d);
        @(negedge clk);
        sel = s; wr_en = w; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wait_ready();
        while (ready_n !== 1'b0) @(negedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        while (rx_active || rp != wp || tx_empty !== 1'b1) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic burst(input logic [6:0] c, input int n);
        host_wr(1, 1, 3'd3, {1'b0, c});
        for (int i = 0; i < n; i++) begin
            wait_ready();
            host_wr(1, 1, 3'd0, 8'($urandom));
        end
        drain();
    endtask

    task automatic send_one(input logic [6:0] c, input logic [7:0] d);
        host_wr(1, 1, 3'd3, {1'b0, c});
        host_wr(1, 1, 3'd0, d);
        drain();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ser_out === 1'b1 && ready_n === 1'b0 && tx_empty === 1'b1, "R1",
              "reset outputs", int'({ser_out, ready_n, tx_empty}), 5);

        // R1: default format 5 bits, no parity, 1 stop; R9/R10 handshake timing
        host_wr(1, 1, 3'd0, 8'hB3);
        check(ready_n === 1'b1 && tx_empty === 1'b0, "R9", "after data write",
              int'({ready_n, tx_empty}), 2);
        @(negedge clk);
        check(ready_n === 1'b0 && tx_empty === 1'b0, "R10", "after take",
              int'({ready_n, tx_empty}), 0);
        drain();

        // R2: ignored writes
        host_wr(0, 1, 3'd0, 8'h11);
        host_wr(1, 0, 3'd0, 8'h22);
        host_wr(1, 1, 3'd1, 8'h33);
        host_wr(1, 0, 3'd3, 8'h40);
        repeat (40) @(negedge clk);
        check(tx_empty === 1'b1 && ser_out === 1'b1 && rp == wp, "R2",
              "ignored writes", int'({tx_empty, ser_out}), 3);

        // R5: 0x55, 5-bit, even parity -> 1
        send_one(7'h18, 8'h55);
        check(last_par === 1'b1, "R5", "parity 0x55 5-bit even", int'(last_par), 1);
        send_one(7'h08, 8'h55);
        check(last_par === 1'b0, "R5", "parity 0x55 5-bit odd", int'(last_par), 0);
        // R6: stick parity
        send_one(7'h3B, 8'h7F);
        check(last_par === 1'b0, "R6", "stick even is 0", int'(last_par), 0);
        send_one(7'h2B, 8'h00);
        check(last_par === 1'b1, "R6", "stick odd is 1", int'(last_par), 1);

        // R7 and R11: 1.5 and 2 stop periods back-to-back
        burst(7'h1C, 3);
        burst(7'h0F, 3);
        burst(7'h06, 2);

        // R13: format write during a frame
        host_wr(1, 1, 3'd3, 7'h1B);
        host_wr(1, 1, 3'd0, 8'hC6);
        repeat (60) @(negedge clk);
        host_wr(1, 1, 3'd3, 7'h04);
        drain();
        send_one(7'h04, 8'h9A);

        // R12: break mid-frame, then at idle
        host_wr(1, 1, 3'd3, 7'h03);
        host_wr(1, 1, 3'd0, 8'hFF);
        repeat (90) @(negedge clk);
        host_wr(1, 1, 3'd3, 8'h43);
        check(ser_out === 1'b0, "R12", "break mid-frame", int'(ser_out), 0);
        repeat (70) @(negedge clk);
        host_wr(1, 1, 3'd3, 8'h03);
        drain();
        host_wr(1, 1, 3'd3, 8'h43);
        repeat (20) @(negedge clk);
        check(ser_out === 1'b0 && tx_empty === 1'b1, "R12", "break at idle",
              int'({ser_out, tx_empty}), 1);
        host_wr(1, 1, 3'd3, 8'h03);
        check(ser_out === 1'b1, "R12", "break released", int'(ser_out), 1);

        // R1: reset during a frame
        host_wr(1, 1, 3'd3, 7'h1F);
        host_wr(1, 1, 3'd0, 8'hA5);
        repeat (80) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ser_out === 1'b1 && ready_n === 1'b0 && tx_empty === 1'b1, "R1",
              "reset mid-frame", int'({ser_out, ready_n, tx_empty}), 5);
        host_wr(1, 1, 3'd0, 8'h5A);
        drain();

        // R4: random formats and bursts
        for (int k = 0; k < 20; k++) begin
            burst(7'($urandom) & 7'h3F, 1 + int'($urandom % 3));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule